// File: doc/BRIEF.md
# Serial EEPROM Slave Protocol Engine

This block is the slave side of a two-wire serial memory holding 8192 bytes. A fast system clock samples the bus clock and data lines. The engine finds start and stop conditions and decodes the device byte. It acknowledges by pulling the data line low through an open-drain enable. In write mode it takes two word-address bytes into a 13-bit address counter, then hands each further data byte to a write controller as a one-cycle strobe. In read mode it shifts out bytes fetched through a combinational memory read port.

The address counter keeps its value between transfers. After any byte is read or written it points one past that location. A write-mode transfer that ends after the two address bytes changes only the counter. A repeated start then turns it into a random read. A read continues byte after byte while the master acknowledges, and the counter wraps from the last location to zero.

States: IDLE (bus not addressed), DEV (device byte in), DEV_ACK, AHI (upper address byte in), AHI_ACK, ALO (lower address byte in), ALO_ACK, WR (data byte in), WR_ACK, RD (data byte out), RD_ACK (master acknowledge bit). The bit-level transitions are:
- DEV→DEV_ACK on an address match, and DEV→IDLE on a mismatch.
- DEV_ACK→AHI for a write, and DEV_ACK→RD for a read.
- AHI→AHI_ACK→ALO→ALO_ACK→WR, then WR→WR_ACK→WR for each data byte.
- RD→RD_ACK, then RD_ACK→RD on a master ACK and RD_ACK→IDLE on a NACK.
- A start condition moves any state to DEV. A stop condition moves any state to IDLE.

Top module: `serial_eeprom_slave`

## Requirements
- R1: A start condition (data falls while clock is high) moves any state, including the middle of a byte, to DEV with a cleared bit count. A stop condition (data rises while clock is high) moves any state to IDLE. A partly received data byte is never reported to the write controller.
- R2: The engine acknowledges a device byte only when its upper seven bits, sent MSB first, equal 1010 followed by strap[2], strap[1], strap[0]. On a mismatch it does not drive the line until the next start.
- R3: The engine drives `sda_oe` high during the ninth clock after a matching device byte, after each address byte and after each write data byte.
- R4: In write mode the first byte after the device byte supplies counter bits 12..8 from its bits 4..0, and its bits 7..5 are ignored. The second byte supplies counter bits 7..0. The counter is loaded when the second byte completes.
- R5: Each complete write data byte gives exactly one `wr_valid` cycle. In that cycle `wr_addr` holds the counter value and `wr_data` holds the byte. The counter then advances by one.
- R6: A write-mode transfer that carries only the two address bytes, followed by a repeated start and a read-mode device byte, returns the byte at the loaded address. It produces no `wr_valid`.
- R7: A read-mode transfer starts at the current counter value, which is the last accessed location plus one.
- R8: After a read byte, a master ACK (data low on the ninth clock) makes the engine send the byte at the next address. A NACK releases the line and ends the read.
- R9: The counter wraps from 0x1FFF to 0x0000, on reads and on writes alike.
- R10: The engine changes what it drives on the data line only while the synchronised clock is low. Data bits are stable through each high phase of the clock.
- R11: After reset, `sda_oe` and `wr_valid` are low and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap | input | 3 | Device address strap bits (tie low for 0) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Pull the data line low when 1 |
| mem_addr | output | 13 | Address counter, used as the read address |
| mem_rdata | input | 8 | Read data for `mem_addr`, combinational |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 13 | Target address of the write byte |
| wr_data | output | 8 | Write byte |

## Verification
The hardest case to reach is a counter wrap inside one sequential read that began with a dummy write. It needs a full write header to 0x1FFE, a repeated start and several master ACKs in a row. The stimulus builds this sequence with bit-level bus tasks and expects each byte from an address pattern computed in the bench. Starts and stops in the middle of a byte are produced by cutting the bit loop short. A sweep over all 128 device byte values checks the address match.

// File: rtl/seep_pkg.sv
package seep_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } seep_state_e;
endpackage

// File: rtl/seep_line_sync.sv
// Two-line synchroniser with clock edge and start/stop detection.
module seep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/seep_addr_ctr.sv
// Persistent address counter with load and wrapping increment.
module seep_addr_ctr #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] cur
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (inc) begin
            cur <= cur + AW'(1);
        end
    end
endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import seep_pkg::*;
#(
    parameter int          ADDR_W      = 13,
    parameter logic [3:0]  TYPE_CODE   = 4'b1010,
    parameter int          SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        strap,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    localparam int HI_W = ADDR_W - 8;

    seep_state_e     state;
    seep_state_e     nstate;
    logic            scl_s;
    logic            sda_s;
    logic            scl_rise;
    logic            scl_fall;
    logic            start_det;
    logic            stop_det;
    logic [3:0]      bitcnt;
    logic [7:0]      rx;
    logic [7:0]      tx;
    logic [HI_W-1:0] hi_q;
    logic            rw_q;
    logic            mack_q;
    logic            byte_done;
    logic            dev_match;
    logic            rx_state;
    logic            ctr_load;
    logic            ctr_inc;
    logic            oe_next;

    seep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    seep_addr_ctr #(.AW(ADDR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val({hi_q, rx}),
        .inc(ctr_inc), .cur(mem_addr)
    );

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign dev_match = (rx[7:1] == {TYPE_CODE, strap});
    assign rx_state  = (state == ST_DEV) || (state == ST_AHI) ||
                       (state == ST_ALO) || (state == ST_WR);
    assign ctr_load  = (state == ST_ALO) && byte_done;
    assign ctr_inc   = ((state == ST_WR) && byte_done) ||
                       ((state == ST_RD) && scl_fall && (bitcnt == 4'd7));

    // Next-state logic
    always_comb begin
        nstate = state;
        if (start_det) begin
            nstate = ST_DEV;
        end else if (stop_det) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    nstate = ST_IDLE;
                ST_DEV:     if (byte_done) nstate = dev_match ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK: if (scl_fall)  nstate = rw_q ? ST_RD : ST_AHI;
                ST_AHI:     if (byte_done) nstate = ST_AHI_ACK;
                ST_AHI_ACK: if (scl_fall)  nstate = ST_ALO;
                ST_ALO:     if (byte_done) nstate = ST_ALO_ACK;
                ST_ALO_ACK: if (scl_fall)  nstate = ST_WR;
                ST_WR:      if (byte_done) nstate = ST_WR_ACK;
                ST_WR_ACK:  if (scl_fall)  nstate = ST_WR;
                ST_RD:      if (scl_fall && bitcnt == 4'd7) nstate = ST_RD_ACK;
                ST_RD_ACK:  if (scl_fall)  nstate = mack_q ? ST_RD : ST_IDLE;
                default:    nstate = ST_IDLE;
            endcase
        end
    end

    // Line drive for the coming state
    always_comb begin
        unique case (nstate)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WR_ACK: oe_next = 1'b1;
            ST_RD: begin
                if (state != ST_RD)  oe_next = ~mem_rdata[7];
                else if (scl_fall)   oe_next = ~tx[6];
                else                 oe_next = sda_oe;
            end
            default: oe_next = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            rx       <= '0;
            tx       <= '0;
            hi_q     <= '0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            sda_oe   <= 1'b0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= 1'b0;
            sda_oe   <= oe_next;
            if (start_det || (nstate != state)) begin
                bitcnt <= '0;
            end else if (rx_state && scl_rise) begin
                bitcnt <= bitcnt + 4'd1;
            end else if ((state == ST_RD) && scl_fall) begin
                bitcnt <= bitcnt + 4'd1;
            end
            if (rx_state && scl_rise) begin
                rx <= {rx[6:0], sda_s};
            end
            if ((state == ST_DEV) && byte_done) begin
                rw_q <= rx[0];
            end
            if ((state == ST_AHI) && byte_done) begin
                hi_q <= rx[HI_W-1:0];
            end
            if ((state == ST_WR) && byte_done && !start_det && !stop_det) begin
                wr_valid <= 1'b1;
                wr_addr  <= mem_addr;
                wr_data  <= rx;
            end
            if ((nstate == ST_RD) && (state != ST_RD)) begin
                tx <= mem_rdata;
            end else if ((state == ST_RD) && scl_fall) begin
                tx <= {tx[6:0], tx[7]};
            end
            if ((state == ST_RD_ACK) && scl_rise) begin
                mack_q <= ~sda_s;
            end
        end
    end
endmodule

// File: rtl/seep_checker.sv
module seep_checker
    import seep_pkg::*;
#(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_sync,
    input logic          sda_oe,
    input logic          wr_valid,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] mem_addr,
    input seep_state_e   state
);
    // R10: the engine starts pulling the line only during a low clock phase
    a_r10_pull_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_sync);

    // R5: a write byte is reported for a single cycle
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R5: the strobe is raised while the byte is being acknowledged
    a_r5_strobe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (state == ST_WR_ACK));

    // R9: the counter moves one past the written address, wrapping at the top
    a_r9_counter_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (mem_addr == AW'(wr_addr + AW'(1))));

    // R1: the line is released whenever the engine is idle
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);
endmodule

bind serial_eeprom_slave seep_checker #(.AW(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_sync(scl_s), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .mem_addr(mem_addr), .state(state)
);

// File: tb/serial_eeprom_slave_test.sv
module serial_eeprom_slave_test;
    localparam int AW = 13;
    localparam int Q  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic [2:0]    strap = 3'b101;
    logic          sda_line;
    logic          sda_oe;
    logic          wr_valid;
    logic [AW-1:0] mem_addr;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic [7:0]    mem_rdata;

    int nchecks = 0;
    int nfail = 0;
    int glitches = 0;
    int wcount = 0;
    logic [AW-1:0] cap_a [0:15];
    logic [7:0]    cap_d [0:15];
    logic done = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
    endfunction

    assign mem_rdata = pat(mem_addr);
    assign sda_line  = sda_m & ~sda_oe;

    serial_eeprom_slave uut (
        .clk(clk), .rst_n(rst_n), .strap(strap), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(posedge clk) begin
        if (rst_n && wr_valid) begin
            if (wcount < 16) begin
                cap_a[wcount] <= wr_addr;
                cap_d[wcount] <= wr_data;
            end
            wcount <= wcount + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    endtask

    task automatic bit_in(output logic b);
        logic s1;
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q/2); s1 = sda_line;
        wq(Q/2); b = sda_line;
        if (s1 !== b) glitches++;
        wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic do_start();
        sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(x);
        ack = ~x;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            bit_in(x);
            d[i] = x;
        end
        bit_out(~mack);
    endtask

    task automatic write_hdr(input logic [7:0] hi, input logic [7:0] lo, input string req);
        logic a;
        do_start();
        send_byte({4'b1010, strap, 1'b0}, a); check({req, " device ack"}, a, 1);
        send_byte(hi, a); check({req, " hi ack"}, a, 1);
        send_byte(lo, a); check({req, " lo ack"}, a, 1);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        int base;
        wq(5);
        rst_n = 1'b1;
        wq(3);
        // R11 reset state
        check("R11 sda_oe", sda_oe, 0);
        check("R11 wr_valid", wr_valid, 0);
        check("R11 mem_addr", mem_addr, 0);

        // R2 sweep of every device byte in write mode
        for (int v = 0; v < 128; v++) begin
            do_start();
            send_byte({v[6:0], 1'b0}, a);
            check("R2 address match", a, (v[6:0] == {4'b1010, strap}) ? 1 : 0);
            do_stop();
        end
        check("R2 no drive after sweep", sda_oe, 0);

        // R3 R4 R5 write of three bytes, upper address bits 7..5 ignored
        base = wcount;
        write_hdr(8'hE3, 8'h40, "R3");
        for (int i = 0; i < 3; i++) begin
            send_byte(8'hC0 + 8'(i), a);
            check("R3 data ack", a, 1);
        end
        do_stop();
        check("R5 strobe count", wcount - base, 3);
        for (int i = 0; i < 3; i++) begin
            check("R4 write address", cap_a[base + i], 13'h0340 + 13'(i));
            check("R5 write data", cap_d[base + i], 8'hC0 + 8'(i));
        end
        check("R5 counter after write", mem_addr, 13'h0343);

        // R7 current-address read
        do_start();
        send_byte({4'b1010, strap, 1'b1}, a); check("R7 device ack", a, 1);
        recv_byte(d, 1'b0);
        check("R7 current read data", d, pat(13'h0343));
        do_stop();

        // R6 R8 R9 dummy write, repeated start, sequential read across the top
        base = wcount;
        write_hdr(8'h1F, 8'hFE, "R6");
        do_start();
        send_byte({4'b1010, strap, 1'b1}, a); check("R6 read device ack", a, 1);
        for (int i = 0; i < 4; i++) begin
            recv_byte(d, (i < 3));
            check("R9 sequential data", d, pat(13'(13'h1FFE + 13'(i))));
        end
        check("R8 released after nack", sda_oe, 0);
        do_stop();
        check("R6 dummy write no strobe", wcount - base, 0);
        check("R8 counter after read", mem_addr, 13'h0002);

        // R1 stop inside a data byte
        base = wcount;
        write_hdr(8'h00, 8'h10, "R1");
        for (int i = 0; i < 4; i++) bit_out(1'b0);
        do_stop();
        check("R1 stop mid byte no strobe", wcount - base, 0);
        do_start();
        send_byte({4'b1010, strap, 1'b1}, a);
        recv_byte(d, 1'b0);
        check("R1 counter kept after abort", d, pat(13'h0010));
        do_stop();

        // R1 start inside an address byte
        do_start();
        send_byte({4'b1010, strap, 1'b0}, a);
        send_byte(8'h05, a);
        for (int i = 0; i < 3; i++) bit_out(1'b1);
        do_start();
        send_byte({4'b1010, strap, 1'b1}, a); check("R1 restart ack", a, 1);
        recv_byte(d, 1'b0);
        check("R1 restart read data", d, pat(13'h0011));
        do_stop();

        // R9 write wrap with masked upper bits
        base = wcount;
        write_hdr(8'hFF, 8'hFF, "R9");
        send_byte(8'hA1, a);
        send_byte(8'hB2, a);
        do_stop();
        check("R9 write count", wcount - base, 2);
        check("R9 first address", cap_a[base], 13'h1FFF);
        check("R9 wrapped address", cap_a[base + 1], 13'h0000);
        check("R9 wrapped data", cap_d[base + 1], 8'hB2);

        // R2 strap tied low
        strap = 3'b000;
        do_start();
        send_byte(8'b1010_0000, a); check("R2 strap zero match", a, 1);
        do_stop();
        do_start();
        send_byte(8'b1010_1010, a); check("R2 strap zero mismatch", a, 0);
        do_stop();

        // R10 stable data through each high clock phase
        check("R10 glitches", glitches, 0);

        done = 1'b1;
        finish_run();
    end
endmodule